// File: doc/BRIEF.md
# Eight-Line Interrupt Controller

The block collects eight interrupt request lines and picks one to hand to a processor. Each request line is edge-latched into a request register. A mask register can hold back any line. The lowest-numbered line that is pending and not masked wins. Its vector, a programmable base plus the line index, is offered to the processor with a valid/acknowledge handshake. A grant is made only while the processor's interrupt-enable input is high.

Software reaches the block through two byte-wide addresses. The command address (`bus_sel`=0) accepts read-select, initialization-start and end-of-interrupt codes. On read, it returns the request register or the in-service register. The data address (`bus_sel`=1) loads the mask. During an initialization sequence it instead takes the setup words. On read, it always returns the mask.

Only one level is in service at a time. In normal mode a grant sets that level's in-service bit, and no further grant is made until an end-of-interrupt command clears it. In automatic end-of-interrupt mode the in-service bit is never set, so the next grant may follow as soon as the vector is acknowledged.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, and `vec_valid` is low.
- R2: A command write of 0x0A makes command reads return the request register, and 0x0B makes them return the in-service register. Bit i of either register is line i. A data read always returns the mask.
- R3: Outside initialization, a data write loads the mask, and bit i set holds line i back. A masked request stays pending and is granted once its mask bit is cleared.
- R4: A rising edge on `irq_in[i]` sets request bit i. A line held high is not latched again after its grant.
- R5: Among pending unmasked lines the lowest index is granted, and its request bit is cleared at the grant.
- R6: The granted vector is the base OR the line index. The base is the first data word after an initialization start, ANDed with 0xF8.
- R7: Command 0x10 starts an initialization that takes two data words: the base, then one word that is discarded. Command 0x11 takes three data words, and the third selects automatic end-of-interrupt when its bit 1 is set. After the last word, data writes load the mask again.
- R8: Once `vec_valid` rises, it and `vec_data` hold until `vec_ack` is sampled high. `vec_valid` is low in the following cycle.
- R9: No grant is made while `cpu_ie` is low. A pending request is granted once `cpu_ie` goes high.
- R10: In normal mode a grant sets the line's in-service bit, and no other grant is made while it is set. Commands 0x20 to 0x27 clear it.
- R11: Commands 0x60 to 0x67 clear the in-service bit only when their low three bits equal the level in service. Otherwise they change nothing.
- R12: In automatic end-of-interrupt mode a grant leaves the in-service register at zero, and a further grant needs no end-of-interrupt command.
- R13: Commands 0xC0 to 0xC7 change no behaviour and raise no error. Any command value not named in R2, R7, R10, R11 or R13 raises `cmd_err` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_sel | input | 1 | Address select: 0 command, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address (combinational) |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| cpu_ie | input | 1 | Processor interrupt enable |
| vec_valid | output | 1 | A vector is being offered |
| vec_data | output | 8 | Offered vector |
| vec_ack | input | 1 | Processor takes the offered vector |
| cmd_err | output | 1 | One-cycle pulse on an unrecognised command |

## Verification
The hardest state to reach is a level in service with a second request waiting behind it. In that state the stimulus can show that a specific end-of-interrupt with the wrong level leaves everything as it was, and that the correct one frees the waiting line.

The bench gets there by raising two lines in the same cycle. It acknowledges the first vector and then holds off the end-of-interrupt. It reads the in-service and request registers through the command address while the second line is still blocked. Automatic mode is reached only through a full three-word initialization, so that sequence is run to completion before that test.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
  localparam int LINES     = 8;
  localparam int IDX_W     = $clog2(LINES);
  localparam int DW        = 8;
  localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << IDX_W) - 1);

  typedef enum logic [1:0] {POS_IDLE, POS_BASE, POS_LINK, POS_MODE} init_pos_e;

  typedef enum logic [2:0] {
    K_RDREQ, K_RDISR, K_INIT2, K_INIT3, K_EOI_NS, K_EOI_SP, K_PRIO, K_BAD
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [DW-1:0] c);
    if (c == 8'h0A)              return K_RDREQ;
    else if (c == 8'h0B)         return K_RDISR;
    else if (c == 8'h10)         return K_INIT2;
    else if (c == 8'h11)         return K_INIT3;
    else if (c[7:3] == 5'b00100) return K_EOI_NS;
    else if (c[7:3] == 5'b01100) return K_EOI_SP;
    else if (c[7:3] == 5'b11000) return K_PRIO;
    else                         return K_BAD;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_idx(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] compose_vector(input logic [DW-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    return base | DW'(idx);
  endfunction
endpackage

// File: rtl/irq_hub_cfg.sv
`timescale 1ns/1ps
module irq_hub_cfg
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [LINES-1:0] mask_q,
  output logic [DW-1:0]    base_q,
  output logic             aeoi_q,
  output logic             rd_isr_q,
  output logic             eoi_ns,
  output logic             eoi_sp,
  output logic [IDX_W-1:0] eoi_lvl,
  output logic             cmd_err
);
  cmd_kind_e kind;
  init_pos_e pos_q, last_q;
  logic      cmd_wr, dat_wr;

  assign kind    = classify(bus_wdata);
  assign cmd_wr  = bus_wr && !bus_sel;
  assign dat_wr  = bus_wr && bus_sel;
  assign eoi_ns  = cmd_wr && (kind == K_EOI_NS);
  assign eoi_sp  = cmd_wr && (kind == K_EOI_SP);
  assign eoi_lvl = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
      rd_isr_q <= 1'b0;
      pos_q    <= POS_IDLE;
      last_q   <= POS_IDLE;
      cmd_err  <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (cmd_wr) begin
        case (kind)
          K_RDREQ: rd_isr_q <= 1'b0;
          K_RDISR: rd_isr_q <= 1'b1;
          K_INIT2: begin pos_q <= POS_BASE; last_q <= POS_LINK; end
          K_INIT3: begin pos_q <= POS_BASE; last_q <= POS_MODE; end
          K_BAD:   cmd_err <= 1'b1;
          default: ;
        endcase
      end
      if (dat_wr) begin
        case (pos_q)
          POS_IDLE: mask_q <= bus_wdata[LINES-1:0];
          POS_BASE: base_q <= bus_wdata & BASE_KEEP;
          POS_MODE: aeoi_q <= bus_wdata[1];
          default:  ;
        endcase
        if (pos_q != POS_IDLE)
          pos_q <= (pos_q == last_q) ? POS_IDLE : init_pos_e'(pos_q + 2'd1);
      end
    end
  end
endmodule

// File: rtl/irq_hub_status.sv
`timescale 1ns/1ps
module irq_hub_status
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             grant_fire,
  input  logic [IDX_W-1:0] grant_idx,
  input  logic             aeoi_q,
  input  logic             eoi_ns,
  input  logic             eoi_sp,
  input  logic [IDX_W-1:0] eoi_lvl,
  output logic [LINES-1:0] req_q,
  output logic [LINES-1:0] isr_q
);
  logic [LINES-1:0] irq_prev, rise, gmask;

  assign rise  = irq_in & ~irq_prev;
  assign gmask = grant_fire ? (LINES'(1) << grant_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= '0;
      req_q    <= '0;
      isr_q    <= '0;
    end else begin
      irq_prev <= irq_in;
      req_q    <= (req_q & ~gmask) | rise;
      if (grant_fire && !aeoi_q)        isr_q <= gmask;
      else if (eoi_ns)                  isr_q <= '0;
      else if (eoi_sp && isr_q[eoi_lvl]) isr_q <= '0;
    end
  end
endmodule

// File: rtl/irq_hub_arb.sv
`timescale 1ns/1ps
module irq_hub_arb
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_q,
  input  logic [LINES-1:0] mask_q,
  input  logic [LINES-1:0] isr_q,
  input  logic [DW-1:0]    base_q,
  input  logic             cpu_ie,
  input  logic             vec_ack,
  output logic             grant_fire,
  output logic [IDX_W-1:0] grant_idx,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_data
);
  logic [LINES-1:0] pending;

  assign pending    = req_q & ~mask_q;
  assign grant_idx  = lowest_idx(pending);
  assign grant_fire = cpu_ie && !(|isr_q) && !vec_valid && (|pending);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else if (grant_fire) begin
      vec_valid <= 1'b1;
      vec_data  <= compose_vector(base_q, grant_idx);
    end else if (vec_valid && vec_ack) begin
      vec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LINES-1:0] irq_in,
  input  logic             cpu_ie,
  output logic             vec_valid,
  output logic [DW-1:0]    vec_data,
  input  logic             vec_ack,
  output logic             cmd_err
);
  logic [LINES-1:0] mask_q, req_q, isr_q;
  logic [DW-1:0]    base_q;
  logic             aeoi_q, rd_isr_q, eoi_ns, eoi_sp, grant_fire;
  logic [IDX_W-1:0] eoi_lvl, grant_idx;

  irq_hub_cfg u_cfg (
    .clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata,
    .mask_q, .base_q, .aeoi_q, .rd_isr_q,
    .eoi_ns, .eoi_sp, .eoi_lvl, .cmd_err
  );

  irq_hub_status u_status (
    .clk, .rst_n, .irq_in, .grant_fire, .grant_idx, .aeoi_q,
    .eoi_ns, .eoi_sp, .eoi_lvl, .req_q, .isr_q
  );

  irq_hub_arb u_arb (
    .clk, .rst_n, .req_q, .mask_q, .isr_q, .base_q, .cpu_ie, .vec_ack,
    .grant_fire, .grant_idx, .vec_valid, .vec_data
  );

  assign bus_rdata = bus_sel  ? DW'(mask_q) :
                     rd_isr_q ? DW'(isr_q)  : DW'(req_q);
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ie,
  input logic             vec_valid,
  input logic [DW-1:0]    vec_data,
  input logic             vec_ack,
  input logic             grant_fire,
  input logic             aeoi_q,
  input logic [LINES-1:0] isr_q
);
  // R10
  one_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q));

  // R10
  busy_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_q) |-> !grant_fire);

  // R9
  grant_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> cpu_ie);

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_data)));

  // R12
  aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && aeoi_q) |=> (isr_q == '0));
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ie(cpu_ie), .vec_valid(vec_valid),
  .vec_data(vec_data), .vec_ack(vec_ack), .grant_fire(grant_fire),
  .aeoi_q(aeoi_q), .isr_q(isr_q)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_sel = 1'b0, cpu_ie = 1'b1, vec_ack = 1'b0;
  logic [7:0] bus_wdata = '0, irq_in = '0;
  logic [7:0] bus_rdata, vec_data;
  logic       vec_valid, cmd_err;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;

  irq_hub u_dut (
    .clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
    .irq_in, .cpu_ie, .vec_valid, .vec_data, .vec_ack, .cmd_err
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d, output logic err);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    err = cmd_err;
  endtask

  task automatic wrq(input logic s, input logic [7:0] d);
    logic e;
    wr(s, d, e);
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    bus_sel = s;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_cmd(input logic isr, output logic [7:0] v);
    wrq(1'b0, isr ? 8'h0B : 8'h0A);
    rd(1'b0, v);
  endtask

  task automatic wait_vec(output logic got, output logic [7:0] v);
    got = 1'b0; v = '0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (vec_valid) begin got = 1'b1; v = vec_data; end
    end
  endtask

  task automatic no_vec(input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vec_valid) seen = 1'b1;
    end
  endtask

  task automatic ack;
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b1, v);          chk(v == 8'hFF, "R1 mask", v, 8'hFF);
    rd(1'b0, v);          chk(v == 8'h00, "R1 request", v, 8'h00);
    chk(vec_valid == 1'b0, "R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    rd_cmd(1'b1, v);      chk(v == 8'h00, "R1 in-service", v, 8'h00);
    wrq(1'b0, 8'h0A);
  endtask

  task automatic t_init_two;
    logic [7:0] v; logic g;
    wrq(1'b0, 8'h10); wrq(1'b1, 8'h8D); wrq(1'b1, 8'h5A);
    rd(1'b1, v);          chk(v == 8'hFF, "R7 init words not in mask", v, 8'hFF);
    wrq(1'b1, 8'hF0);
    rd(1'b1, v);          chk(v == 8'hF0, "R7 mask after two words R2", v, 8'hF0);
    @(negedge clk); irq_in = 8'h02;
    wait_vec(g, v);       chk(g && v == 8'h89, "R6 base 0x88 line 1", v, 8'h89);
    irq_in = 8'h00; ack(); wrq(1'b0, 8'h20);
  endtask

  task automatic t_priority;
    logic [7:0] v; logic g, s;
    wrq(1'b0, 8'h11); wrq(1'b1, 8'h40); wrq(1'b1, 8'h00); wrq(1'b1, 8'h00);
    wrq(1'b1, 8'h00);
    @(negedge clk); irq_in = 8'h24;
    wait_vec(g, v);       chk(g && v == 8'h42, "R5 R6 lowest line wins", v, 8'h42);
    irq_in = 8'h00;
    no_vec(0, s);
    repeat (3) @(negedge clk);
    chk(vec_valid && vec_data == 8'h42, "R8 vector held", vec_data, 8'h42);
    rd(1'b0, v);          chk(v == 8'h20, "R5 granted bit cleared", v, 8'h20);
    rd_cmd(1'b1, v);      chk(v == 8'h04, "R10 in-service set", v, 8'h04);
    ack();
    chk(!vec_valid, "R8 drop after ack", {7'b0, vec_valid}, 8'h00);
    no_vec(6, s);         chk(!s, "R10 blocked while in service", {7'b0, s}, 8'h00);
    wrq(1'b0, 8'h20);
    wait_vec(g, v);       chk(g && v == 8'h45, "R10 next after EOI", v, 8'h45);
    ack();
    wrq(1'b0, 8'h63);
    rd(1'b0, v);          chk(v == 8'h20, "R11 wrong level ignored", v, 8'h20);
    wrq(1'b0, 8'h65);
    rd(1'b0, v);          chk(v == 8'h00, "R11 matching level clears", v, 8'h00);
    wrq(1'b0, 8'h0A);
  endtask

  task automatic t_mask;
    logic [7:0] v; logic g, s;
    wrq(1'b1, 8'h08);
    @(negedge clk); irq_in = 8'h08;
    @(negedge clk); irq_in = 8'h00;
    no_vec(6, s);         chk(!s, "R3 masked not granted", {7'b0, s}, 8'h00);
    rd(1'b0, v);          chk(v == 8'h08, "R3 masked still pending", v, 8'h08);
    wrq(1'b1, 8'h00);
    wait_vec(g, v);       chk(g && v == 8'h43, "R3 granted after unmask", v, 8'h43);
    ack(); wrq(1'b0, 8'h20);
  endtask

  task automatic t_level;
    logic [7:0] v; logic g, s;
    @(negedge clk); irq_in = 8'h02;
    wait_vec(g, v);       chk(g && v == 8'h41, "R4 edge latched", v, 8'h41);
    ack(); wrq(1'b0, 8'h20);
    no_vec(6, s);         chk(!s, "R4 held level not relatched", {7'b0, s}, 8'h00);
    rd(1'b0, v);          chk(v == 8'h00, "R4 request empty", v, 8'h00);
    @(negedge clk); irq_in = 8'h00;
  endtask

  task automatic t_ie;
    logic [7:0] v; logic g, s;
    @(negedge clk); cpu_ie = 1'b0; irq_in = 8'h01;
    @(negedge clk); irq_in = 8'h00;
    no_vec(6, s);         chk(!s, "R9 no grant with ie low", {7'b0, s}, 8'h00);
    cpu_ie = 1'b1;
    wait_vec(g, v);       chk(g && v == 8'h40, "R9 grant after ie", v, 8'h40);
    ack(); wrq(1'b0, 8'h20);
  endtask

  task automatic t_cmds;
    logic [7:0] v; logic g, e;
    wr(1'b0, 8'hC3, e);   chk(!e, "R13 priority cmd no error", {7'b0, e}, 8'h00);
    @(negedge clk); irq_in = 8'h81;
    wait_vec(g, v);       chk(g && v == 8'h40, "R13 priority unchanged", v, 8'h40);
    irq_in = 8'h00; ack(); wrq(1'b0, 8'h20);
    wait_vec(g, v);       chk(g && v == 8'h47, "R13 second line", v, 8'h47);
    ack(); wrq(1'b0, 8'h67);
    wr(1'b0, 8'h55, e);   chk(e, "R13 bad cmd error", {7'b0, e}, 8'h01);
    @(negedge clk);       chk(!cmd_err, "R13 error one cycle", {7'b0, cmd_err}, 8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] v; logic g;
    wrq(1'b0, 8'h11); wrq(1'b1, 8'h80); wrq(1'b1, 8'h00); wrq(1'b1, 8'h02);
    @(negedge clk); irq_in = 8'h10;
    wait_vec(g, v);       chk(g && v == 8'h84, "R7 R12 auto mode vector", v, 8'h84);
    irq_in = 8'h00;
    rd_cmd(1'b1, v);      chk(v == 8'h00, "R12 no in-service", v, 8'h00);
    ack();
    @(negedge clk); irq_in = 8'h40;
    wait_vec(g, v);       chk(g && v == 8'h86, "R12 grant without EOI", v, 8'h86);
    irq_in = 8'h00; ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_two();
    t_priority();
    t_mask();
    t_level();
    t_ie();
    t_cmds();
    t_aeoi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule